// File: doc/BRIEF.md
# Serial Audio Link Frame Receiver

This block is the receiving half of a synchronous serial audio link, as seen from the codec side. The controller drives a frame marker (SYNC) and a serial data line, both timed by the bit clock. The receiver finds the start of each frame and checks that every frame runs its full 256 bits. It reads the 16-bit tag slot that opens the frame and picks out the first four 20-bit data slots. Slots 1 and 2 are the two control words and slots 3 and 4 are the left and right PCM samples.

A slot word is taken only when the frame is marked valid and the slot's own tag bit is set. All accepted words and their one-cycle strobes appear together with a frame-done pulse when the frame ends. The receiver does not act on the control words, does no sample processing and does not build the return frame.

Top module: `alink_rx`

## Requirements
- R1: While reset is asserted, and after it is released, all slot words read 0 and all strobes and `frame_done_o` are 0. No frame is received until the first SYNC rise is seen, whatever the data line does.
- R2: SYNC is sampled on rising clock edges. A frame starts at the rising edge where SYNC is sampled 1 after being sampled 0. The first frame bit is the one driven just after that edge.
- R3: The data line is sampled on the falling clock edge that follows the rising edge where the bit was driven. The value present at the next rising edge has no effect.
- R4: A frame is 256 bits long. Bits 0..15 form the tag slot. Data slot n (n = 1..4) occupies bits 16+20*(n-1) to 35+20*(n-1), most significant bit first. `frame_done_o` pulses for one cycle, 256 rising edges after the start edge.
- R5: A SYNC rise seen before the current frame has taken in all 256 bits does not start a frame. The frame in progress is then discarded: no `frame_done_o` pulse, no strobe and no word change.
- R6: A SYNC rise seen on the same edge that takes in bit 255 starts the next frame, so frames can follow back to back.
- R7: When tag bit 0 (frame valid) is 0, no slot word changes and no strobe fires. `frame_done_o` still pulses.
- R8: Slot n (n = 1..4) is accepted only when tag bit 0 and tag bit n are both 1. Its word then loads the slot data. A slot that is not accepted keeps its previous word.
- R9: Each slot strobe is high for exactly the cycle in which `frame_done_o` is high, and only for accepted slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | Frame marker; a rise starts a frame |
| sdata_i | input | 1 | Serial frame data, driven on rising edges |
| ctl_a_word_o | output | 20 | Slot 1 control word |
| ctl_b_word_o | output | 20 | Slot 2 control word |
| pcm_l_word_o | output | 20 | Slot 3 left sample |
| pcm_r_word_o | output | 20 | Slot 4 right sample |
| ctl_a_vld_o | output | 1 | Slot 1 accepted this frame |
| ctl_b_vld_o | output | 1 | Slot 2 accepted this frame |
| pcm_l_vld_o | output | 1 | Slot 3 accepted this frame |
| pcm_r_vld_o | output | 1 | Slot 4 accepted this frame |
| frame_done_o | output | 1 | One-cycle pulse at the end of each complete frame |

## Verification
The checks on frame spacing assume that the controller changes SYNC and data only just after rising edges. They also assume that SYNC stays low through reset, so that no rise is seen before the first real frame. The stimulus drives every input one time unit after a rising edge and holds SYNC low during reset. The only exception is the falling-edge test, which also flips the data line just after the falling edge; this change lies inside the window that the receiver must ignore. The frame-gap check relies on frames never being shorter than 256 bits, which the premature-rise test stresses on purpose.

// File: rtl/alink_rx_pkg.sv
package alink_rx_pkg;
  localparam int unsigned CAP_SLOTS = 4;

  typedef enum logic [1:0] {
    SLOT_CTL_A = 2'd0,
    SLOT_CTL_B = 2'd1,
    SLOT_PCM_L = 2'd2,
    SLOT_PCM_R = 2'd3
  } cap_slot_e;

  // Index of the last bit of captured slot idx (0-based, slot idx+1 on the link)
  function automatic int unsigned slot_last_bit(int unsigned tag_bits,
                                                int unsigned slot_bits,
                                                int unsigned idx);
    return tag_bits + slot_bits * (idx + 1) - 1;
  endfunction
endpackage

// File: rtl/alink_rx_front.sv
module alink_rx_front (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  input  logic sdata_i,
  output logic rise_o,
  output logic bit_o
);
  logic sd_hold_q;
  logic sync_q;

  // data captured mid-bit, handed to the rising-edge domain
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sd_hold_q <= 1'b0;
    else         sd_hold_q <= sdata_i;
  end

  // reset high so a marker held through reset is not a rise
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 1'b1;
    else         sync_q <= sync_i;
  end

  assign rise_o = sync_i & ~sync_q;
  assign bit_o  = sd_hold_q;
endmodule

// File: rtl/alink_rx_framer.sv
module alink_rx_framer #(
  parameter int unsigned FRAME_BITS = 256,
  parameter int unsigned CNT_W      = $clog2(FRAME_BITS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  output logic             bit_vld_o,
  output logic [CNT_W-1:0] bit_idx_o,
  output logic             commit_o
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_BITS - 1);

  logic             active_q;
  logic             bad_q;
  logic [CNT_W-1:0] cnt_q;
  logic             at_last;

  assign at_last = active_q && (cnt_q == LAST_IDX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      bad_q    <= 1'b0;
      cnt_q    <= '0;
    end else if (at_last) begin
      active_q <= rise_i;   // back-to-back start
      bad_q    <= 1'b0;
      cnt_q    <= '0;
    end else if (active_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (rise_i) bad_q <= 1'b1;  // early marker: ignore it, drop this frame
    end else if (rise_i) begin
      active_q <= 1'b1;
      bad_q    <= 1'b0;
      cnt_q    <= '0;
    end
  end

  assign bit_vld_o = active_q;
  assign bit_idx_o = cnt_q;
  assign commit_o  = at_last && !bad_q;
endmodule

// File: rtl/alink_rx_slots.sv
module alink_rx_slots
  import alink_rx_pkg::*;
#(
  parameter int unsigned TAG_BITS  = 16,
  parameter int unsigned SLOT_BITS = 20,
  parameter int unsigned CNT_W     = 8
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                bit_vld_i,
  input  logic [CNT_W-1:0]                    bit_idx_i,
  input  logic                                bit_i,
  input  logic                                commit_i,
  output logic [CAP_SLOTS-1:0][SLOT_BITS-1:0] word_o,
  output logic [CAP_SLOTS-1:0]                vld_o,
  output logic                                done_o
);
  logic [SLOT_BITS-1:0] shift_q;
  logic [SLOT_BITS-1:0] shift_nx;
  logic [CAP_SLOTS:0]   tag_q;
  logic                 done_q;

  assign shift_nx = {shift_q[SLOT_BITS-2:0], bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q <= '0;
      tag_q   <= '0;
    end else if (bit_vld_i) begin
      shift_q <= shift_nx;
      for (int t = 0; t <= CAP_SLOTS; t++) begin
        if (bit_idx_i == CNT_W'(t)) tag_q[t] <= bit_i;
      end
    end
  end

  for (genvar g = 0; g < CAP_SLOTS; g++) begin : g_slot
    localparam logic [CNT_W-1:0] END_IDX = CNT_W'(slot_last_bit(TAG_BITS, SLOT_BITS, g));
    logic [SLOT_BITS-1:0] stage_q;
    logic [SLOT_BITS-1:0] word_q;
    logic                 vld_q;
    logic                 take;

    assign take = commit_i && tag_q[0] && tag_q[g+1];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q <= '0;
        word_q  <= '0;
        vld_q   <= 1'b0;
      end else begin
        if (bit_vld_i && bit_idx_i == END_IDX) stage_q <= shift_nx;
        if (take) word_q <= stage_q;
        vld_q <= take;
      end
    end

    assign word_o[g] = word_q;
    assign vld_o[g]  = vld_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_q <= 1'b0;
    else         done_q <= commit_i;
  end

  assign done_o = done_q;
endmodule

// File: rtl/alink_rx.sv
module alink_rx
  import alink_rx_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 256,
  parameter int unsigned TAG_BITS   = 16,
  parameter int unsigned SLOT_BITS  = 20
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sync_i,
  input  logic                 sdata_i,
  output logic [SLOT_BITS-1:0] ctl_a_word_o,
  output logic [SLOT_BITS-1:0] ctl_b_word_o,
  output logic [SLOT_BITS-1:0] pcm_l_word_o,
  output logic [SLOT_BITS-1:0] pcm_r_word_o,
  output logic                 ctl_a_vld_o,
  output logic                 ctl_b_vld_o,
  output logic                 pcm_l_vld_o,
  output logic                 pcm_r_vld_o,
  output logic                 frame_done_o
);
  localparam int unsigned CNT_W = $clog2(FRAME_BITS);

  logic                                rise;
  logic                                rx_bit;
  logic                                bit_vld;
  logic [CNT_W-1:0]                    bit_idx;
  logic                                commit;
  logic [CAP_SLOTS-1:0][SLOT_BITS-1:0] words;
  logic [CAP_SLOTS-1:0]                vlds;

  alink_rx_front u_front (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sync_i (sync_i),
    .sdata_i(sdata_i),
    .rise_o (rise),
    .bit_o  (rx_bit)
  );

  alink_rx_framer #(
    .FRAME_BITS(FRAME_BITS),
    .CNT_W     (CNT_W)
  ) u_framer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rise_i   (rise),
    .bit_vld_o(bit_vld),
    .bit_idx_o(bit_idx),
    .commit_o (commit)
  );

  alink_rx_slots #(
    .TAG_BITS (TAG_BITS),
    .SLOT_BITS(SLOT_BITS),
    .CNT_W    (CNT_W)
  ) u_slots (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bit_vld_i(bit_vld),
    .bit_idx_i(bit_idx),
    .bit_i    (rx_bit),
    .commit_i (commit),
    .word_o   (words),
    .vld_o    (vlds),
    .done_o   (frame_done_o)
  );

  assign ctl_a_word_o = words[SLOT_CTL_A];
  assign ctl_b_word_o = words[SLOT_CTL_B];
  assign pcm_l_word_o = words[SLOT_PCM_L];
  assign pcm_r_word_o = words[SLOT_PCM_R];
  assign ctl_a_vld_o  = vlds[SLOT_CTL_A];
  assign ctl_b_vld_o  = vlds[SLOT_CTL_B];
  assign pcm_l_vld_o  = vlds[SLOT_PCM_L];
  assign pcm_r_vld_o  = vlds[SLOT_PCM_R];
endmodule

// File: rtl/alink_rx_chk.sv
module alink_rx_chk #(
  parameter int unsigned FRAME_BITS = 256,
  parameter int unsigned SLOT_BITS  = 20
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 sync_i,
  input logic [SLOT_BITS-1:0] ctl_a_word_o,
  input logic [SLOT_BITS-1:0] ctl_b_word_o,
  input logic [SLOT_BITS-1:0] pcm_l_word_o,
  input logic [SLOT_BITS-1:0] pcm_r_word_o,
  input logic                 ctl_a_vld_o,
  input logic                 ctl_b_vld_o,
  input logic                 pcm_l_vld_o,
  input logic                 pcm_r_vld_o,
  input logic                 frame_done_o
);
  localparam int unsigned GAP_W = $clog2(FRAME_BITS) + 2;

  logic             sync_prev_q;
  logic             seen_rise_q;
  logic             seen_done_q;
  logic [GAP_W-1:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_prev_q <= 1'b1;
      seen_rise_q <= 1'b0;
      seen_done_q <= 1'b0;
      gap_q       <= '0;
    end else begin
      sync_prev_q <= sync_i;
      if (sync_i && !sync_prev_q) seen_rise_q <= 1'b1;
      if (frame_done_o) begin
        seen_done_q <= 1'b1;
        gap_q       <= GAP_W'(1);
      end else if (gap_q != '1) begin
        gap_q <= gap_q + 1'b1;
      end
    end
  end

  // R1
  no_frame_before_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_rise_q |-> !frame_done_o);

  // R4
  frame_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_done_o && seen_done_q) |-> (gap_q >= GAP_W'(FRAME_BITS)));

  // R4
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |=> !frame_done_o);

  // R9
  strobe_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_a_vld_o || ctl_b_vld_o || pcm_l_vld_o || pcm_r_vld_o) |-> frame_done_o);

  // R8
  ctl_a_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_a_vld_o |-> $stable(ctl_a_word_o));

  // R8
  ctl_b_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_b_vld_o |-> $stable(ctl_b_word_o));

  // R8
  pcm_l_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pcm_l_vld_o |-> $stable(pcm_l_word_o));

  // R8
  pcm_r_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pcm_r_vld_o |-> $stable(pcm_r_word_o));
endmodule

bind alink_rx alink_rx_chk #(
  .FRAME_BITS(FRAME_BITS),
  .SLOT_BITS (SLOT_BITS)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sync_i      (sync_i),
  .ctl_a_word_o(ctl_a_word_o),
  .ctl_b_word_o(ctl_b_word_o),
  .pcm_l_word_o(pcm_l_word_o),
  .pcm_r_word_o(pcm_r_word_o),
  .ctl_a_vld_o (ctl_a_vld_o),
  .ctl_b_vld_o (ctl_b_vld_o),
  .pcm_l_vld_o (pcm_l_vld_o),
  .pcm_r_vld_o (pcm_r_vld_o),
  .frame_done_o(frame_done_o)
);

// File: tb/alink_rx_tb.sv
module alink_rx_tb;
  localparam int FB = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync = 1'b0;
  logic        sdata = 1'b0;
  logic [19:0] w_a, w_b, w_l, w_r;
  logic        v_a, v_b, v_l, v_r, done;

  int checks = 0;
  int fails = 0;
  int done_cnt = 0;
  logic [19:0] e_a = '0, e_b = '0, e_l = '0, e_r = '0;

  always #5 clk = ~clk;

  alink_rx u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sync_i(sync), .sdata_i(sdata),
    .ctl_a_word_o(w_a), .ctl_b_word_o(w_b), .pcm_l_word_o(w_l), .pcm_r_word_o(w_r),
    .ctl_a_vld_o(v_a), .ctl_b_vld_o(v_b), .pcm_l_vld_o(v_l), .pcm_r_vld_o(v_r),
    .frame_done_o(done)
  );

  always @(negedge clk) if (rst_n && done) done_cnt++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // tag bit 0 = frame valid, tag bit n = slot n; slot n at 16+20*(n-1), MSB first
  function automatic logic [FB-1:0] mk(input logic v, input logic [3:0] tg,
                                       input logic [19:0] a, b, l, r);
    logic [FB-1:0] fr;
    logic [19:0] w [4];
    w[0] = a; w[1] = b; w[2] = l; w[3] = r;
    for (int k = 0; k < FB; k++) fr[k] = k[0] ^ k[2];
    fr[0] = v;
    for (int n = 1; n <= 4; n++) fr[n] = tg[n-1];
    for (int s = 0; s < 4; s++)
      for (int j = 0; j < 20; j++) fr[16 + 20*s + j] = w[s][19-j];
    return fr;
  endfunction

  task automatic start_sync();
    @(posedge clk); #1 sync = 1'b1;
  endtask

  task automatic send(input logic [FB-1:0] fr, input bit chain, input int early, input bit glitch);
    for (int k = 0; k < FB; k++) begin
      @(posedge clk); #1;
      sdata = fr[k];
      if (k == 15) sync = 1'b0;
      if (early > 0 && k == early) sync = 1'b1;
      if (early > 0 && k == early + 4) sync = 1'b0;
      if (chain && k == FB - 1) sync = 1'b1;
      if (glitch) begin
        @(negedge clk); #1 sdata = ~fr[k];
      end
    end
  endtask

  task automatic settle();
    @(posedge clk); @(negedge clk); #1;
  endtask

  task automatic chk_words(input string req);
    chk({req, " ctl_a"}, 32'(w_a), 32'(e_a));
    chk({req, " ctl_b"}, 32'(w_b), 32'(e_b));
    chk({req, " pcm_l"}, 32'(w_l), 32'(e_l));
    chk({req, " pcm_r"}, 32'(w_r), 32'(e_r));
  endtask

  task automatic t_reset();
    #1;
    chk("R1 reset words", 32'({w_a, w_b} | {w_l, w_r}), 32'h0);
    chk("R1 reset strobes", 32'({v_a, v_b, v_l, v_r, done}), 32'h0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", 32'({v_a, v_b, v_l, v_r, done}), 32'h0);
  endtask

  task automatic t_idle();
    int d0 = done_cnt;
    for (int k = 0; k < 300; k++) begin
      @(posedge clk); #1 sdata = k[0] ^ k[1];
    end
    settle();
    chk("R1 no frame without sync", 32'(done_cnt - d0), 32'd0);
    chk_words("R1 idle");
  endtask

  task automatic t_full();
    int d0 = done_cnt;
    e_a = 20'hA5C3E; e_b = 20'h1F00D; e_l = 20'h80001; e_r = 20'h7FFFE;
    start_sync();
    send(mk(1'b1, 4'b1111, e_a, e_b, e_l, e_r), 0, 0, 0);
    settle();
    chk("R4 frame_done pulse", 32'(done), 32'd1);
    chk("R2 one frame", 32'(done_cnt - d0), 32'd1);
    chk("R9 all strobes", 32'({v_a, v_b, v_l, v_r}), 32'hF);
    chk_words("R4 slot words");
    @(negedge clk);
    chk("R9 strobes one cycle", 32'({v_a, v_b, v_l, v_r, done}), 32'h0);
  endtask

  task automatic t_partial();
    e_a = 20'h12345; e_r = 20'hFEDCB;
    start_sync();
    send(mk(1'b1, 4'b1001, e_a, 20'hBAD01, 20'hBAD02, e_r), 0, 0, 0);
    settle();
    chk("R8 strobes slots 1,4", 32'({v_a, v_b, v_l, v_r}), 32'h9);
    chk_words("R8 untagged keep");
  endtask

  task automatic t_invalid();
    int d0 = done_cnt;
    start_sync();
    send(mk(1'b0, 4'b1111, 20'h0DEAD, 20'h0BEEF, 20'h0CAFE, 20'h0F00D), 0, 0, 0);
    settle();
    chk("R7 done still pulses", 32'(done_cnt - d0), 32'd1);
    chk("R7 no strobes", 32'({v_a, v_b, v_l, v_r}), 32'h0);
    chk_words("R7 words unchanged");
  endtask

  task automatic t_premature();
    int d0 = done_cnt;
    start_sync();
    send(mk(1'b1, 4'b1111, 20'h11111, 20'h22222, 20'h33333, 20'h44444), 0, 100, 0);
    settle();
    repeat (4) @(negedge clk);
    chk("R5 no done after early sync", 32'(done_cnt - d0), 32'd0);
    chk_words("R5 words unchanged");
  endtask

  task automatic t_recover();
    e_b = 20'h5A5A5; e_l = 20'hC0DE1;
    start_sync();
    send(mk(1'b1, 4'b0110, 20'hBAD03, e_b, e_l, 20'hBAD04), 0, 0, 0);
    settle();
    chk("R5 recovery strobes", 32'({v_a, v_b, v_l, v_r}), 32'h6);
    chk_words("R5 recovery words");
  endtask

  task automatic t_chain();
    int d0 = done_cnt;
    e_b = 20'h2468A;
    e_a = 20'h13579;
    start_sync();
    send(mk(1'b1, 4'b0010, 20'hBAD05, e_b, 20'hBAD06, 20'hBAD07), 1, 0, 0);
    send(mk(1'b1, 4'b0001, e_a, 20'hBAD08, 20'hBAD09, 20'hBAD0A), 0, 0, 0);
    settle();
    chk("R6 two frames back to back", 32'(done_cnt - d0), 32'd2);
    chk("R6 second strobes", 32'({v_a, v_b, v_l, v_r}), 32'h8);
    chk_words("R6 chained words");
  endtask

  task automatic t_fall();
    e_l = 20'h9ABCD; e_r = 20'h03C5A;
    start_sync();
    send(mk(1'b1, 4'b1100, 20'hBAD0B, 20'hBAD0C, e_l, e_r), 0, 0, 1);
    settle();
    chk("R3 falling-edge strobes", 32'({v_a, v_b, v_l, v_r}), 32'h3);
    chk_words("R3 falling-edge words");
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_idle();
    t_full();
    t_partial();
    t_invalid();
    t_premature();
    t_recover();
    t_chain();
    t_fall();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule